// File: doc/BRIEF.md
# Programmable Multi-Mode Timer Channel

This block is a single 16-bit counter channel with a small register interface. It counts events on a primary input. A control field selects the active edge: rising, falling or both. The same counter can instead count clock cycles while the primary input is high, which measures the width of a pulse. It can also decode two phase-shifted inputs as a quadrature pair, or count edges of the primary input in a direction chosen by the secondary input.

Two compare registers set the terminal count: one for counting up and one for counting down. On reaching the terminal count the counter either reloads from a load register at once, or keeps counting and wraps through zero. A control bit selects one-shot or repeat operation. A rising secondary input can latch the count into a capture register. Reading the counter copies its value into a hold register.

The sequencer has three states. `ST_IDLE` is entered while the source field is off. `ST_RUN` is where counting happens. `ST_DONE` is where a one-shot run stops. There are five transitions:
- IDLE→RUN when the source field becomes non-zero.
- RUN→IDLE when the source is switched off.
- RUN→DONE on a compare hit with one-shot set.
- DONE→RUN on any control write that leaves the source on.
- DONE→IDLE when the source is switched off.

Top module: `timer_channel`

## Requirements
- R1: After reset, every register reads 0, and `cmp_flag`, `cap_flag` and `out_tog` are 0. The register map is: address 0 up-compare, 1 down-compare, 2 capture, 3 load, 4 hold, 5 counter, 6 control, 7 status. Control bits are: [2:0] source, [3] one-shot, [4] reload-at-compare, [5] capture enable. Status bits are: [0] compare flag, [1] capture flag.
- R2: Source 1 counts rising edges of `in_pri`, source 2 counts falling edges, and source 3 counts both edges. Edges of the wrong polarity leave the count unchanged.
- R3: Source 4 adds one for every clock cycle in which the synchronised `in_pri` is high.
- R4: Source 5 treats {`in_pri`,`in_sec`} as a quadrature pair. Steps 00→01→11→10→00 count up, and the reverse steps count down. A change of both inputs at once leaves the count unchanged.
- R5: Source 6 counts rising edges of `in_pri`. It counts up while `in_sec` is 0 and down while `in_sec` is 1.
- R6: With reload-at-compare set, an up step taken at a count equal to the up-compare, or a down step taken at a count equal to the down-compare, loads the load register instead of stepping.
- R7: With reload-at-compare clear, the counter steps through the compare value and wraps from 0xFFFF to 0.
- R8: With one-shot set, the first compare hit ends counting. The count stays fixed until the control register is written again.
- R9: A compare hit sets `cmp_flag` at the clock edge of the hit. Writing 1 to status bit 0 clears it. A hit and a clear in the same cycle leave the flag set.
- R10: With capture enabled, a rising `in_sec` latches the counter into the capture register and sets `cap_flag`. Further captures are blocked until status bit 1 is cleared by writing 1.
- R11: A read of the counter address copies the count into the hold register, and later reads of the hold register return that value.
- R12: `out_tog` inverts on every compare hit and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (counter read updates hold) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| in_pri | input | 1 | Primary count / gate / phase A input |
| in_sec | input | 1 | Secondary direction / phase B / capture input |
| cmp_flag | output | 1 | Compare flag |
| cap_flag | output | 1 | Capture flag |
| out_tog | output | 1 | Output that toggles on each compare hit |

## Verification
A compare hit and a write-1 clear of the compare flag can occur in the same cycle. The bench provokes this by holding a status clear write on every cycle while gated counting with reload at compare produces a hit every eleven clocks. Set has priority, so the flag must be high for exactly one sampled cycle per hit. The bench therefore judges the overlap by requiring the number of flag-high samples to equal the number of `out_tog` changes, and to be at least four.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CMP_UP = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMP_DN = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CAP    = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LOAD   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_HOLD   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT    = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd7;

    typedef enum logic [2:0] {
        SRC_OFF  = 3'd0,
        SRC_RISE = 3'd1,
        SRC_FALL = 3'd2,
        SRC_BOTH = 3'd3,
        SRC_GATE = 3'd4,
        SRC_QUAD = 3'd5,
        SRC_DIR  = 3'd6
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic [9:0] spare;
        logic       cap_en;
        logic       reinit;
        logic       one_shot;
        logic [2:0] src;
    } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1, s2, s3;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                    s3 <= 1'b0;
                end else begin
                    s1 <= din[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign cur[g] = s2;
            assign prv[g] = s3;
        end
    endgenerate
endmodule

// File: rtl/tmr_step_decode.sv
module tmr_step_decode
    import tmr_pkg::*;
(
    input  logic [2:0] src,
    input  logic       a_cur,
    input  logic       a_prv,
    input  logic       b_cur,
    input  logic       b_prv,
    output logic       step,
    output logic       up
);
    logic [3:0] quad_tr;
    assign quad_tr = {a_prv, b_prv, a_cur, b_cur};

    always_comb begin
        step = 1'b0;
        up   = 1'b1;
        case (src_e'(src))
            SRC_RISE: step = a_cur & ~a_prv;
            SRC_FALL: step = ~a_cur & a_prv;
            SRC_BOTH: step = a_cur ^ a_prv;
            SRC_GATE: step = a_cur;
            SRC_DIR: begin
                step = a_cur & ~a_prv;
                up   = ~b_cur;
            end
            SRC_QUAD: begin
                case (quad_tr)
                    4'b0001, 4'b0111, 4'b1110, 4'b1000: begin
                        step = 1'b1;
                        up   = 1'b1;
                    end
                    4'b0100, 4'b1101, 4'b1011, 4'b0010: begin
                        step = 1'b1;
                        up   = 1'b0;
                    end
                    default: begin
                        step = 1'b0;
                        up   = 1'b1;
                    end
                endcase
            end
            default: step = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          up,
    input  logic          src_on,
    input  logic          one_shot,
    input  logic          reinit,
    input  logic          ctrl_wr,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [CW-1:0] cmp_up,
    input  logic [CW-1:0] cmp_dn,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          hit,
    output logic          tog
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          tog_q;
    logic          running;

    assign running = (state_q == ST_RUN);
    assign hit = running && step && (up ? (cnt_q == cmp_up) : (cnt_q == cmp_dn));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (src_on) state_d = ST_RUN;
            ST_RUN: begin
                if (!src_on)              state_d = ST_IDLE;
                else if (hit && one_shot) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!src_on)      state_d = ST_IDLE;
                else if (ctrl_wr) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else begin
            if (cnt_wr)                cnt_q <= cnt_wdata;
            else if (hit && reinit)    cnt_q <= load_val;
            else if (running && step)  cnt_q <= up ? cnt_q + 1'b1 : cnt_q - 1'b1;
            if (hit) tog_q <= ~tog_q;
        end
    end

    assign cnt = cnt_q;
    assign tog = tog_q;

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !cnt_wr) |=> $stable(cnt_q));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && reinit && !cnt_wr) |=> (cnt_q == $past(load_val)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && up && !reinit && !cnt_wr && cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              in_pri,
    input  logic              in_sec,
    output logic              cmp_flag,
    output logic              cap_flag,
    output logic              out_tog
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] cmp_up_q, cmp_dn_q, load_q, hold_q, cap_q;
    logic              cmp_flag_q, cap_flag_q;
    logic [1:0]        in_cur, in_prv;
    logic              step, up, hit, tog;
    logic [DATA_W-1:0] cnt;
    logic              cap_evt, sec_rise;
    logic              wr_ctrl, wr_cnt, wr_stat, wr_cap;

    assign wr_ctrl = bus_wr && bus_addr == ADR_CTRL;
    assign wr_cnt  = bus_wr && bus_addr == ADR_CNT;
    assign wr_stat = bus_wr && bus_addr == ADR_STAT;
    assign wr_cap  = bus_wr && bus_addr == ADR_CAP;

    tmr_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({in_pri, in_sec}),
        .cur  (in_cur),
        .prv  (in_prv)
    );

    tmr_step_decode u_dec (
        .src  (ctrl_q.src),
        .a_cur(in_cur[1]),
        .a_prv(in_prv[1]),
        .b_cur(in_cur[0]),
        .b_prv(in_prv[0]),
        .step (step),
        .up   (up)
    );

    tmr_core #(.CW(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .up       (up),
        .src_on   (ctrl_q.src != 3'd0 && ctrl_q.src != 3'd7),
        .one_shot (ctrl_q.one_shot),
        .reinit   (ctrl_q.reinit),
        .ctrl_wr  (wr_ctrl),
        .cnt_wr   (wr_cnt),
        .cnt_wdata(bus_wdata),
        .cmp_up   (cmp_up_q),
        .cmp_dn   (cmp_dn_q),
        .load_val (load_q),
        .cnt      (cnt),
        .hit      (hit),
        .tog      (tog)
    );

    assign sec_rise = in_cur[0] & ~in_prv[0];
    assign cap_evt  = ctrl_q.cap_en && sec_rise && !cap_flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cmp_up_q <= '0;
            cmp_dn_q <= '0;
            load_q   <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADR_CMP_UP: cmp_up_q <= bus_wdata;
                ADR_CMP_DN: cmp_dn_q <= bus_wdata;
                ADR_LOAD:   load_q   <= bus_wdata;
                ADR_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            cap_q      <= '0;
            cmp_flag_q <= 1'b0;
            cap_flag_q <= 1'b0;
        end else begin
            if (bus_rd && bus_addr == ADR_CNT)                hold_q <= cnt;
            else if (bus_wr && bus_addr == ADR_HOLD)          hold_q <= bus_wdata;
            if (cap_evt)      cap_q <= cnt;
            else if (wr_cap)  cap_q <= bus_wdata;
            if (hit)                         cmp_flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) cmp_flag_q <= 1'b0;
            if (cap_evt)                     cap_flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[1]) cap_flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CMP_UP: bus_rdata = cmp_up_q;
            ADR_CMP_DN: bus_rdata = cmp_dn_q;
            ADR_CAP:    bus_rdata = cap_q;
            ADR_LOAD:   bus_rdata = load_q;
            ADR_HOLD:   bus_rdata = hold_q;
            ADR_CNT:    bus_rdata = cnt;
            ADR_CTRL:   bus_rdata = ctrl_q;
            default:    bus_rdata = {{(DATA_W-2){1'b0}}, cap_flag_q, cmp_flag_q};
        endcase
    end

    assign cmp_flag = cmp_flag_q;
    assign cap_flag = cap_flag_q;
    assign out_tog  = tog;

    // R9
    cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cmp_flag_q);

    // R10
    cap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_q && !(wr_stat && bus_wdata[1]) && !wr_cap) |=> ($stable(cap_q) && cap_flag_q));

    // R4
    quad_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.src == SRC_QUAD && in_cur[1] != in_prv[1] && in_cur[0] != in_prv[0]) |-> !step);

    // R12
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(out_tog));
endmodule

// File: tb/timer_channel_tb.sv
`timescale 1ns/1ps
module timer_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        in_pri = 1'b0, in_sec = 1'b0;
    logic        cmp_flag, cap_flag, out_tog;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_pri(in_pri), .in_sec(in_sec), .cmp_flag(cmp_flag),
        .cap_flag(cap_flag), .out_tog(out_tog)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) in_pri = 1'b1;
            idle(3);
            in_pri = 1'b0;
            idle(3);
        end
        idle(4);
    endtask

    function automatic logic [15:0] ctl(input int src, input bit os, input bit ri, input bit ce);
        return 16'(src) | (16'(os) << 3) | (16'(ri) << 4) | (16'(ce) << 5);
    endfunction

    function automatic int reload_model(input int start, input int cmp, input int ld, input int n);
        int c = start;
        for (int i = 0; i < n; i++) c = (c == cmp) ? ld : c + 1;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [1:0]  qseq [4];
        int          qi, exp_c, flag_hi, tog_ch;
        logic        last_tog;
        qseq[0] = 2'b00; qseq[1] = 2'b01; qseq[2] = 2'b11; qseq[3] = 2'b10;

        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg", d, 16'h0000);
        end
        check("R1 flags", {14'd0, cmp_flag, cap_flag}, 16'd0);
        check("R1 tog", {15'd0, out_tog}, 16'd0);

        // R2: edge selection
        wr(3'd6, ctl(1, 0, 0, 0)); wr(3'd5, 0); pulse(7);
        rd(3'd5, d); check("R2 rising", d, 16'd7);
        wr(3'd6, ctl(2, 0, 0, 0)); wr(3'd5, 0); pulse(5);
        rd(3'd5, d); check("R2 falling", d, 16'd5);
        @(negedge clk) in_pri = 1'b1; idle(5);
        rd(3'd5, d); check("R2 falling ignores rise", d, 16'd5);
        in_pri = 1'b0; idle(5);
        wr(3'd6, ctl(3, 0, 0, 0)); wr(3'd5, 0); pulse(4);
        rd(3'd5, d); check("R2 both", d, 16'd8);

        // R3: gated counting
        wr(3'd6, ctl(4, 0, 0, 0)); wr(3'd5, 0);
        @(negedge clk) in_pri = 1'b1;
        idle(13);
        in_pri = 1'b0; idle(5);
        rd(3'd5, d); check("R3 gated width", d, 16'd13);

        // R4: quadrature sweep
        wr(3'd6, ctl(5, 0, 0, 0)); wr(3'd5, 100);
        qi = 0; exp_c = 100;
        for (int i = 0; i < 6; i++) begin
            qi = (qi + 1) % 4; {in_pri, in_sec} = qseq[qi]; exp_c++; idle(5);
        end
        rd(3'd5, d); check("R4 quad up", d, 16'(exp_c));
        for (int i = 0; i < 3; i++) begin
            qi = (qi + 3) % 4; {in_pri, in_sec} = qseq[qi]; exp_c--; idle(5);
        end
        rd(3'd5, d); check("R4 quad down", d, 16'(exp_c));
        qi = (qi + 2) % 4; {in_pri, in_sec} = qseq[qi]; idle(5);
        rd(3'd5, d); check("R4 quad invalid ignored", d, 16'(exp_c));
        qi = (qi + 1) % 4; {in_pri, in_sec} = qseq[qi]; exp_c++; idle(5);
        rd(3'd5, d); check("R4 quad after invalid", d, 16'(exp_c));
        wr(3'd6, 0); {in_pri, in_sec} = 2'b00; idle(5);

        // R5: count with direction
        wr(3'd6, ctl(6, 0, 0, 0)); wr(3'd5, 50); pulse(4);
        rd(3'd5, d); check("R5 dir up", d, 16'd54);
        in_sec = 1'b1; idle(5); pulse(6);
        rd(3'd5, d); check("R5 dir down", d, 16'd48);

        // R6: reload at down-compare
        wr(3'd1, 2); wr(3'd3, 9); wr(3'd6, ctl(6, 0, 1, 0)); wr(3'd5, 4); pulse(3);
        rd(3'd5, d); check("R6 down reload", d, 16'd9);
        in_sec = 1'b0; idle(5);

        // R6: reload at up-compare, swept
        for (int cv = 3; cv <= 9; cv += 3) begin
            wr(3'd0, 16'(cv)); wr(3'd3, 1); wr(3'd6, ctl(1, 0, 1, 0)); wr(3'd5, 0);
            pulse(12);
            rd(3'd5, d); check("R6 up reload", d, 16'(reload_model(0, cv, 1, 12)));
        end

        // R7 / R9: roll through compare and wrap
        wr(3'd7, 16'h3); wr(3'd0, 3); wr(3'd6, ctl(1, 0, 0, 0)); wr(3'd5, 16'hFFFE);
        pulse(7);
        rd(3'd5, d); check("R7 wrap through", d, 16'd5);
        check("R9 flag set", {15'd0, cmp_flag}, 16'd1);
        wr(3'd7, 16'h1);
        check("R9 flag cleared", {15'd0, cmp_flag}, 16'd0);

        // R8 / R12: one-shot
        last_tog = out_tog;
        wr(3'd0, 3); wr(3'd3, 0); wr(3'd6, ctl(1, 1, 1, 0)); wr(3'd5, 0);
        pulse(10);
        rd(3'd5, d); check("R8 one-shot stopped", d, 16'd0);
        check("R12 single toggle", {15'd0, out_tog ^ last_tog}, 16'd1);
        wr(3'd6, ctl(1, 1, 1, 0)); pulse(2);
        rd(3'd5, d); check("R8 rearm", d, 16'd2);

        // R10: capture with blocking
        wr(3'd6, ctl(1, 0, 0, 1)); wr(3'd7, 16'h3); wr(3'd5, 30);
        @(negedge clk) in_sec = 1'b1; idle(5); in_sec = 1'b0; idle(5);
        rd(3'd2, d); check("R10 capture", d, 16'd30);
        check("R10 cap flag", {15'd0, cap_flag}, 16'd1);
        pulse(2);
        @(negedge clk) in_sec = 1'b1; idle(5); in_sec = 1'b0; idle(5);
        rd(3'd2, d); check("R10 capture blocked", d, 16'd30);
        wr(3'd7, 16'h2);
        check("R10 flag cleared", {15'd0, cap_flag}, 16'd0);
        @(negedge clk) in_sec = 1'b1; idle(5); in_sec = 1'b0; idle(5);
        rd(3'd2, d); check("R10 recapture", d, 16'd32);

        // R11: hold register coherence
        wr(3'd6, ctl(1, 0, 0, 0)); wr(3'd5, 20);
        rd(3'd5, d); check("R11 counter read", d, 16'd20);
        pulse(3);
        rd(3'd4, d); check("R11 hold keeps old", d, 16'd20);
        rd(3'd5, d); check("R11 counter advanced", d, 16'd23);

        // R9 / R12: hit and clear in the same cycle
        wr(3'd7, 16'h3); wr(3'd0, 10); wr(3'd3, 0);
        wr(3'd6, ctl(4, 0, 1, 0)); wr(3'd5, 0);
        flag_hi = 0; tog_ch = 0;
        @(negedge clk);
        last_tog = out_tog;
        in_pri = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 16'h1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cmp_flag) flag_hi++;
            if (out_tog != last_tog) tog_ch++;
            last_tog = out_tog;
        end
        bus_wr = 1'b0; in_pri = 1'b0; idle(5);
        check("R9 set wins over clear", 16'(flag_hi), 16'(tog_ch));
        check("R12 hits seen", 16'(tog_ch >= 4), 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule